// File: doc/BRIEF.md
# Interrupt Pin Service and End-of-Interrupt Engine

This block sits between a bank of interrupt input lines and the fabric that carries interrupts to the processors. Each pin owns a routing entry with a vector, a destination, a delivery mode, a trigger mode and a mask. The block turns line activity into service requests and keeps a pending bit per pin. It sends one delivery request at a time, which carries the entry's routing fields and the pin number. The fabric returns a single bit that says whether at least one target took the interrupt. Encoding of the message toward the processors is done elsewhere.

Level-triggered pins are held off by a per-pin in-service flag. A delivery that a target accepts sets the flag. Only an end-of-interrupt notice whose vector matches the entry clears it. When a level line is still asserted at that notice, the pin is serviced again at once. A per-pin counter tracks these back-to-back re-deliveries. When the counter reaches its limit, the immediate re-delivery is dropped and a deferred sweep runs after a programmable number of cycles. That sweep services every level pin that is asserted and not in service. This lets a guest that never clears its device source still make forward progress.

Top module: `irq_pin_engine`

## Requirements
- R1: A service attempt for a pin whose mask bit is set sends nothing and is consumed. Clearing the mask later does not by itself produce a delivery.
- R2: A level-triggered pin whose in-service flag is set is never delivered.
- R3: A level delivery that the fabric accepts (`dlv_accepted_i`=1 at the handshake) sets the pin's in-service flag. A declined level delivery leaves the flag clear.
- R4: On an edge pin, a rising line edge creates a request. A second rising edge that arrives before the first has been delivered or dropped pulses that pin's bit of `coal_o` for one cycle and adds no delivery. Once the first request has finished, a new edge is delivered normally.
- R5: On a level pin, the pending bit follows the line, and a rising edge of the line creates a request.
- R6: An end-of-interrupt notice acts only when `eoi_level_i`=1. It applies to every level entry whose vector equals `eoi_vector_i` and clears that entry's in-service flag. Notices with another vector, or with `eoi_level_i`=0, change nothing.
- R7: If a matching notice finds the pin unmasked with its line still asserted, the pin is delivered again and its counter is incremented. Otherwise the counter returns to zero.
- R8: The notice that would bring the counter to STORM_LIMIT causes no immediate delivery. It clears the counter and starts a deferred sweep that runs DEFER_CYCLES cycles later.
- R9: The deferred sweep requests service for every level pin whose line is asserted and whose in-service flag is clear.
- R10: A write that leaves an entry level-triggered while its pending bit is set triggers a service attempt. A write that makes an entry edge-triggered clears its in-service flag.
- R11: When several pins are ready, they are served in ascending pin order, one at a time. `dlv_valid_o` and the payload stay steady until `dlv_ready_i`.
- R12: After reset, every entry is masked and edge-triggered, nothing is pending, and `dlv_valid_o` and `coal_o` are 0.
- R13: Layout of `cfg_data_i`: vector [7:0], destination [15:8], delivery mode [18:16], logical-destination flag [19], level-trigger flag [20], mask [21].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | NPINS | Interrupt input lines |
| cfg_we_i | input | 1 | Routing entry write strobe |
| cfg_pin_i | input | PIN_W | Entry being written |
| cfg_data_i | input | 22 | New entry contents (layout in R13) |
| eoi_valid_i | input | 1 | End-of-interrupt notice strobe |
| eoi_level_i | input | 1 | Notice refers to a level-triggered interrupt |
| eoi_vector_i | input | 8 | Vector being acknowledged |
| dlv_valid_o | output | 1 | Delivery request pending |
| dlv_ready_i | input | 1 | Fabric takes the request this cycle |
| dlv_accepted_i | input | 1 | At least one target accepted (valid with ready) |
| dlv_vector_o | output | 8 | Vector of the request |
| dlv_dest_o | output | 8 | Destination of the request |
| dlv_dmode_o | output | 3 | Delivery mode of the request |
| dlv_logical_o | output | 1 | Logical-destination flag of the request |
| dlv_level_o | output | 1 | Request is level-triggered |
| dlv_pin_o | output | PIN_W | Pin that raised the request |
| coal_o | output | NPINS | One-cycle pulse per pin for a coalesced edge |

## Verification
The bench first drives a level line through a declined delivery and then rewrites its entry. A design that set the in-service flag on a decline would go silent here, and one that ignored the flag would send a second copy after an accepted delivery. Notices with the wrong vector or with the edge flag are sent while a level pin is in service. A design that applied them would re-deliver, and one that applied a matching notice to only one of two sharing entries would miss a delivery or break ascending order. The storm sequence checks that the limit-th notice is silent for the whole deferred window and that the sweep then serves the right pins in order. A second edge during a stalled handshake must pulse `coal_o` and must not add a delivery.

// File: rtl/ipe_pkg.sv
package ipe_pkg;

    localparam int VEC_W   = 8;
    localparam int DEST_W  = 8;
    localparam int DMODE_W = 3;

    // Routing entry; packed order gives vector at the LSBs (R13)
    typedef struct packed {
        logic               mask;
        logic               lvl;
        logic               logical;
        logic [DMODE_W-1:0] dmode;
        logic [DEST_W-1:0]  dest;
        logic [VEC_W-1:0]   vector;
    } rte_t;

    localparam int RTE_W = $bits(rte_t);

    localparam rte_t RTE_RESET = '{mask: 1'b1, lvl: 1'b0, logical: 1'b0,
                                   dmode: '0, dest: '0, vector: '0};

    function automatic logic eoi_hits(input rte_t e, input logic [VEC_W-1:0] v);
        return e.lvl && (e.vector == v);
    endfunction

    function automatic logic may_send(input rte_t e, input logic in_service);
        return !e.mask && !(e.lvl && in_service);
    endfunction

endpackage

// File: rtl/ipe_pin_slot.sv
module ipe_pin_slot
    import ipe_pkg::*;
#(
    parameter int STORM_LIMIT = 10000,
    parameter int CNT_W       = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_i,
    input  logic             cfg_we_i,
    input  rte_t             cfg_ent_i,
    input  logic             eoi_valid_i,
    input  logic             eoi_level_i,
    input  logic [VEC_W-1:0] eoi_vec_i,
    input  logic             defer_fire_i,
    input  logic             grant_i,
    input  logic             done_i,
    input  logic             done_lvl_i,
    input  logic             acc_i,
    output rte_t             ent_o,
    output logic             want_o,
    output logic             elig_o,
    output logic             rirr_o,
    output logic             storm_o,
    output logic             coal_o
);

    rte_t             ent_q;
    logic             line_q, irr_q, rirr_q, want_q, coal_q;
    logic [CNT_W-1:0] cnt_q;

    logic rise, edge_clr, irr_kept, eoi_hit, redo_ok, cnt_wrap;
    logic set_rise, set_cfg, set_eoi, set_def;
    logic rirr_nxt;

    assign rise     = line_i & ~line_q;
    assign elig_o   = may_send(ent_q, rirr_q);
    // edge pending bit is consumed by a finished delivery or a dropped attempt
    assign edge_clr = (done_i & ~done_lvl_i) | (grant_i & ~elig_o & ~ent_q.lvl);
    assign irr_kept = irr_q & ~edge_clr;
    assign eoi_hit  = eoi_valid_i & eoi_level_i & eoi_hits(ent_q, eoi_vec_i);
    assign redo_ok  = ~ent_q.mask & irr_q;
    assign cnt_wrap = (cnt_q == CNT_W'(STORM_LIMIT - 1));
    assign storm_o  = eoi_hit & redo_ok & cnt_wrap;

    assign set_rise = rise & (ent_q.lvl | ~irr_kept);
    assign set_cfg  = cfg_we_i & cfg_ent_i.lvl & irr_q;
    assign set_eoi  = eoi_hit & redo_ok & ~cnt_wrap;
    assign set_def  = defer_fire_i & ent_q.lvl & irr_q & ~rirr_q;

    always_comb begin
        rirr_nxt = rirr_q;
        if (eoi_hit)
            rirr_nxt = 1'b0;
        if (done_i && acc_i && done_lvl_i)
            rirr_nxt = 1'b1;
        if (cfg_we_i && !cfg_ent_i.lvl)
            rirr_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q  <= RTE_RESET;
            line_q <= 1'b0;
            irr_q  <= 1'b0;
            rirr_q <= 1'b0;
            want_q <= 1'b0;
            coal_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            line_q <= line_i;
            irr_q  <= ent_q.lvl ? line_i : (irr_kept | rise);
            coal_q <= ~ent_q.lvl & rise & irr_kept;
            rirr_q <= rirr_nxt;
            want_q <= (want_q & ~grant_i) | set_rise | set_cfg | set_eoi | set_def;
            if (cfg_we_i)
                ent_q <= cfg_ent_i;
            if (eoi_hit)
                cnt_q <= (redo_ok && !cnt_wrap) ? cnt_q + 1'b1 : '0;
        end
    end

    assign ent_o  = ent_q;
    assign want_o = want_q;
    assign rirr_o = rirr_q;
    assign coal_o = coal_q;

endmodule

// File: rtl/ipe_pick_first.sv
module ipe_pick_first #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  onehot_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);

    always_comb begin
        onehot_o = '0;
        idx_o    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                onehot_o    = '0;
                onehot_o[i] = 1'b1;
                idx_o       = IW'(i);
            end
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/ipe_defer_timer.sv
module ipe_defer_timer #(
    parameter int DELAY = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    output logic fire_o
);

    localparam int CW = $clog2(DELAY + 1);

    logic          running_q, fire_q;
    logic [CW-1:0] cnt_q;
    logic          at_end;

    assign at_end = running_q && (cnt_q == CW'(DELAY - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            fire_q    <= 1'b0;
            cnt_q     <= '0;
        end else begin
            fire_q <= at_end;
            if (arm_i && (!running_q || at_end)) begin
                running_q <= 1'b1;
                cnt_q     <= '0;
            end else if (at_end) begin
                running_q <= 1'b0;
            end else if (running_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign fire_o = fire_q;

endmodule

// File: rtl/irq_pin_engine.sv
module irq_pin_engine
    import ipe_pkg::*;
#(
    parameter int   NPINS        = 8,
    parameter int   STORM_LIMIT  = 10000,
    parameter int   DEFER_CYCLES = 1000000,
    localparam int  PIN_W        = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NPINS-1:0]   line_i,
    input  logic               cfg_we_i,
    input  logic [PIN_W-1:0]   cfg_pin_i,
    input  logic [RTE_W-1:0]   cfg_data_i,
    input  logic               eoi_valid_i,
    input  logic               eoi_level_i,
    input  logic [VEC_W-1:0]   eoi_vector_i,
    output logic               dlv_valid_o,
    input  logic               dlv_ready_i,
    input  logic               dlv_accepted_i,
    output logic [VEC_W-1:0]   dlv_vector_o,
    output logic [DEST_W-1:0]  dlv_dest_o,
    output logic [DMODE_W-1:0] dlv_dmode_o,
    output logic               dlv_logical_o,
    output logic               dlv_level_o,
    output logic [PIN_W-1:0]   dlv_pin_o,
    output logic [NPINS-1:0]   coal_o
);

    localparam int CNT_W = $clog2(STORM_LIMIT + 1);

    rte_t             ent_v [NPINS];
    logic [NPINS-1:0] want_v, elig_v, rirr_vec, storm_v, mask_vec;
    logic [NPINS-1:0] grant_vec, done_vec, pick_oh;
    logic [PIN_W-1:0] pick_idx;
    logic             pick_any, defer_fire, launch, hs;
    rte_t             cfg_ent;

    logic             busy_q;
    rte_t             pay_q;
    logic [PIN_W-1:0] pay_pin_q;

    assign cfg_ent = rte_t'(cfg_data_i);

    ipe_pick_first #(.N(NPINS), .IW(PIN_W)) u_pick (
        .req_i    (want_v),
        .onehot_o (pick_oh),
        .idx_o    (pick_idx),
        .any_o    (pick_any)
    );

    ipe_defer_timer #(.DELAY(DEFER_CYCLES)) u_defer (
        .clk    (clk),
        .rst    (rst),
        .arm_i  (|storm_v),
        .fire_o (defer_fire)
    );

    assign grant_vec = busy_q ? '0 : pick_oh;
    assign launch    = !busy_q && pick_any && elig_v[pick_idx];
    assign hs        = busy_q && dlv_ready_i;
    assign done_vec  = hs ? (NPINS'(1) << pay_pin_q) : '0;

    for (genvar g = 0; g < NPINS; g++) begin : g_slot
        ipe_pin_slot #(.STORM_LIMIT(STORM_LIMIT), .CNT_W(CNT_W)) u_slot (
            .clk          (clk),
            .rst          (rst),
            .line_i       (line_i[g]),
            .cfg_we_i     (cfg_we_i && (cfg_pin_i == PIN_W'(g))),
            .cfg_ent_i    (cfg_ent),
            .eoi_valid_i  (eoi_valid_i),
            .eoi_level_i  (eoi_level_i),
            .eoi_vec_i    (eoi_vector_i),
            .defer_fire_i (defer_fire),
            .grant_i      (grant_vec[g]),
            .done_i       (done_vec[g]),
            .done_lvl_i   (pay_q.lvl),
            .acc_i        (dlv_accepted_i),
            .ent_o        (ent_v[g]),
            .want_o       (want_v[g]),
            .elig_o       (elig_v[g]),
            .rirr_o       (rirr_vec[g]),
            .storm_o      (storm_v[g]),
            .coal_o       (coal_o[g])
        );
        assign mask_vec[g] = ent_v[g].mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            pay_q     <= RTE_RESET;
            pay_pin_q <= '0;
        end else if (launch) begin
            busy_q    <= 1'b1;
            pay_q     <= ent_v[pick_idx];
            pay_pin_q <= pick_idx;
        end else if (hs) begin
            busy_q    <= 1'b0;
        end
    end

    assign dlv_valid_o   = busy_q;
    assign dlv_vector_o  = pay_q.vector;
    assign dlv_dest_o    = pay_q.dest;
    assign dlv_dmode_o   = pay_q.dmode;
    assign dlv_logical_o = pay_q.logical;
    assign dlv_level_o   = pay_q.lvl;
    assign dlv_pin_o     = pay_pin_q;

endmodule

// File: rtl/ipe_checker.sv
module ipe_checker #(
    parameter int NPINS = 8,
    parameter int PIN_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             dlv_valid,
    input logic             dlv_ready,
    input logic             dlv_accepted,
    input logic             dlv_level,
    input logic [PIN_W-1:0] dlv_pin,
    input logic [7:0]       dlv_vector,
    input logic             cfg_we,
    input logic [PIN_W-1:0] cfg_pin,
    input logic [NPINS-1:0] mask_vec,
    input logic [NPINS-1:0] rirr_vec,
    input logic [NPINS-1:0] grant_vec
);

    AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
        dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_pin) && $stable(dlv_vector)); // R11

    AST_MASKED_NOT_SENT: assert property (@(posedge clk) disable iff (rst)
        $rose(dlv_valid) |-> (($past(mask_vec) & (NPINS'(1) << dlv_pin)) == '0)); // R1

    AST_LEVEL_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(dlv_valid) && dlv_level |-> (($past(rirr_vec) & (NPINS'(1) << dlv_pin)) == '0)); // R2

    AST_ACCEPT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        dlv_valid && dlv_ready && dlv_accepted && dlv_level && !(cfg_we && cfg_pin == dlv_pin)
        |=> ((rirr_vec & (NPINS'(1) << $past(dlv_pin))) != '0)); // R3

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_vec)); // R11

endmodule

bind irq_pin_engine ipe_checker #(.NPINS(NPINS), .PIN_W(PIN_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .dlv_valid    (dlv_valid_o),
    .dlv_ready    (dlv_ready_i),
    .dlv_accepted (dlv_accepted_i),
    .dlv_level    (dlv_level_o),
    .dlv_pin      (dlv_pin_o),
    .dlv_vector   (dlv_vector_o),
    .cfg_we       (cfg_we_i),
    .cfg_pin      (cfg_pin_i),
    .mask_vec     (mask_vec),
    .rirr_vec     (rirr_vec),
    .grant_vec    (grant_vec)
);

// File: tb/irq_pin_engine_bench.sv
module irq_pin_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NP  = 4;
    localparam int LIM = 4;
    localparam int DEF = 50;
    localparam int PW  = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] lines = '0;
    logic          cfg_we = 1'b0;
    logic [PW-1:0] cfg_pin = '0;
    logic [21:0]   cfg_data = '0;
    logic          eoi_valid = 1'b0, eoi_level = 1'b0;
    logic [7:0]    eoi_vec = '0;
    logic          rdy = 1'b1, acc = 1'b1;
    logic          dlv_valid, dlv_logical, dlv_level;
    logic [7:0]    dlv_vector, dlv_dest;
    logic [2:0]    dlv_dmode;
    logic [PW-1:0] dlv_pin;
    logic [NP-1:0] coal;

    int checks = 0, failures = 0;
    bit finished = 0;
    string cur_tag = "R12";

    int    exp_pin[$];
    int    exp_vec[$];
    int    exp_dest[$];
    string exp_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pin_engine #(.NPINS(NP), .STORM_LIMIT(LIM), .DEFER_CYCLES(DEF)) u_irq_pin_engine (
        .clk(clk), .rst(rst), .line_i(lines),
        .cfg_we_i(cfg_we), .cfg_pin_i(cfg_pin), .cfg_data_i(cfg_data),
        .eoi_valid_i(eoi_valid), .eoi_level_i(eoi_level), .eoi_vector_i(eoi_vec),
        .dlv_valid_o(dlv_valid), .dlv_ready_i(rdy), .dlv_accepted_i(acc),
        .dlv_vector_o(dlv_vector), .dlv_dest_o(dlv_dest), .dlv_dmode_o(dlv_dmode),
        .dlv_logical_o(dlv_logical), .dlv_level_o(dlv_level), .dlv_pin_o(dlv_pin),
        .coal_o(coal)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // R13 layout, computed here from the requirement
    function automatic logic [21:0] mk(input int vec, input int dest, input int dm,
                                        input bit logical, input bit lvl, input bit mask);
        return {mask, lvl, logical, 3'(dm), 8'(dest), 8'(vec)};
    endfunction

    task automatic cfg(input int pin, input logic [21:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_pin = PW'(pin); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_line(input int pin, input bit v);
        @(negedge clk);
        lines[pin] = v;
    endtask

    task automatic eoi(input int vec, input bit lvl);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vec = 8'(vec); eoi_level = lvl;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic expect_dlv(input int pin, input int vec, input int dest, input string tag);
        exp_pin.push_back(pin);
        exp_vec.push_back(vec);
        exp_dest.push_back(dest);
        exp_tag.push_back(tag);
    endtask

    task automatic settle(input string tag);
        repeat (12) @(negedge clk);
        check(exp_pin.size() == 0, tag, "missing deliveries", exp_pin.size(), 0);
        exp_pin.delete(); exp_vec.delete(); exp_dest.delete(); exp_tag.delete();
    endtask

    // scoreboard monitor: a handshake is seen before the edge that takes it
    always @(negedge clk) begin
        if (!rst && dlv_valid && rdy) begin
            if (exp_pin.size() == 0) begin
                check(1'b0, cur_tag, "unexpected delivery on pin", int'(dlv_pin), -1);
            end else begin
                check(int'(dlv_pin) == exp_pin[0], exp_tag[0], "delivery pin",
                      int'(dlv_pin), exp_pin[0]);
                check(int'(dlv_vector) == exp_vec[0], exp_tag[0], "delivery vector",
                      int'(dlv_vector), exp_vec[0]);
                check(int'(dlv_dest) == exp_dest[0], exp_tag[0], "delivery dest",
                      int'(dlv_dest), exp_dest[0]);
                void'(exp_pin.pop_front()); void'(exp_vec.pop_front());
                void'(exp_dest.pop_front()); void'(exp_tag.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(dlv_valid == 1'b0, "R12", "dlv_valid after reset", dlv_valid, 0);
        check(coal == '0, "R12", "coal after reset", coal, 0);
        cur_tag = "R12";
        set_line(0, 1);
        settle("R12");
        set_line(0, 0);

        // R11 / R13: stalled edge delivery, payload held; R4 coalesced edge
        cfg(1, mk(8'h31, 8'h5A, 5, 1, 0, 0));
        rdy = 1'b0;
        cur_tag = "R11";
        expect_dlv(1, 8'h31, 8'h5A, "R13");
        set_line(1, 1);
        repeat (6) @(negedge clk);
        check(dlv_valid == 1'b1, "R11", "valid held", dlv_valid, 1);
        check(dlv_dmode == 3'd5 && dlv_logical && !dlv_level, "R13", "mode fields",
              {dlv_dmode, dlv_logical, dlv_level}, 'b10110);
        check(int'(dlv_pin) == 1, "R11", "pin held", dlv_pin, 1);
        set_line(1, 0);
        set_line(1, 1);
        @(negedge clk);
        check(coal == 4'b0010, "R4", "coalesced pulse", coal, 2);
        @(negedge clk);
        check(coal == 4'b0000, "R4", "pulse one cycle", coal, 0);
        rdy = 1'b1;
        cur_tag = "R4";
        settle("R4");
        set_line(1, 0);
        expect_dlv(1, 8'h31, 8'h5A, "R4");
        set_line(1, 1);
        @(negedge clk);
        check(coal == 4'b0000, "R4", "fresh edge not coalesced", coal, 0);
        settle("R4");
        set_line(1, 0);

        // R1: masked edge dropped, unmask gives nothing
        cfg(2, mk(8'h22, 0, 0, 0, 0, 1));
        cur_tag = "R1";
        set_line(2, 1);
        settle("R1");
        cfg(2, mk(8'h22, 0, 0, 0, 0, 0));
        settle("R1");
        set_line(2, 0);
        expect_dlv(2, 8'h22, 0, "R1");
        set_line(2, 1);
        settle("R1");
        set_line(2, 0);

        // level pin 3
        cfg(3, mk(8'h40, 8'h03, 0, 0, 1, 0));
        cur_tag = "R10";
        settle("R10");
        cur_tag = "R5";
        expect_dlv(3, 8'h40, 8'h03, "R5");
        set_line(3, 1);
        settle("R5");
        cur_tag = "R6";
        eoi(8'h40, 0);
        eoi(8'h41, 1);
        settle("R6");
        cur_tag = "R2";
        cfg(3, mk(8'h40, 8'h03, 0, 0, 1, 0));
        settle("R2");
        cur_tag = "R7";
        expect_dlv(3, 8'h40, 8'h03, "R7");
        eoi(8'h40, 1);
        settle("R7");
        set_line(3, 0);
        eoi(8'h40, 1);
        settle("R7");
        // R3: declined delivery leaves flag clear
        acc = 1'b0;
        cur_tag = "R3";
        expect_dlv(3, 8'h40, 8'h03, "R3");
        set_line(3, 1);
        settle("R3");
        acc = 1'b1;
        expect_dlv(3, 8'h40, 8'h03, "R3");
        cfg(3, mk(8'h40, 8'h03, 0, 0, 1, 0));
        settle("R3");
        // R10: switch to edge clears flag, back to level re-attempts
        cur_tag = "R10";
        cfg(3, mk(8'h40, 8'h03, 0, 0, 0, 0));
        expect_dlv(3, 8'h40, 8'h03, "R10");
        cfg(3, mk(8'h40, 8'h03, 0, 0, 1, 0));
        settle("R10");
        set_line(3, 0);
        eoi(8'h40, 1);
        settle("R10");

        // R6 / R11: two level entries share a vector
        cfg(0, mk(8'h50, 8'h10, 0, 0, 1, 0));
        cfg(3, mk(8'h50, 8'h13, 0, 0, 1, 0));
        cur_tag = "R11";
        expect_dlv(0, 8'h50, 8'h10, "R11");
        expect_dlv(3, 8'h50, 8'h13, "R11");
        @(negedge clk);
        lines[0] = 1'b1; lines[3] = 1'b1;
        settle("R11");
        cur_tag = "R6";
        expect_dlv(0, 8'h50, 8'h10, "R6");
        expect_dlv(3, 8'h50, 8'h13, "R6");
        eoi(8'h50, 1);
        settle("R6");
        @(negedge clk);
        lines[0] = 1'b0; lines[3] = 1'b0;
        eoi(8'h50, 1);
        settle("R6");

        // R8 / R9: storm throttle and deferred sweep
        cfg(0, mk(8'h61, 8'h20, 0, 0, 1, 0));
        cfg(3, mk(8'h60, 8'h23, 0, 0, 1, 0));
        acc = 1'b0;
        cur_tag = "R9";
        expect_dlv(0, 8'h61, 8'h20, "R9");
        set_line(0, 1);
        settle("R9");
        acc = 1'b1;
        cur_tag = "R7";
        expect_dlv(3, 8'h60, 8'h23, "R7");
        set_line(3, 1);
        settle("R7");
        for (int k = 1; k < LIM; k++) begin
            expect_dlv(3, 8'h60, 8'h23, "R7");
            eoi(8'h60, 1);
            settle("R7");
        end
        cur_tag = "R8";
        eoi(8'h60, 1);
        repeat (DEF - 3) @(negedge clk);
        cur_tag = "R9";
        expect_dlv(0, 8'h61, 8'h20, "R9");
        expect_dlv(3, 8'h60, 8'h23, "R9");
        settle("R8");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule